// File: doc/BRIEF.md
# Dual Decade Counter with Split Divide-by-Two and Divide-by-Five Stages

This block holds two independent counter channels. Each channel is built from a one-bit stage and a modulo-five stage. Each stage has its own clock pin and its own count. A stage advances when its pin goes from high to low. Those transitions are detected against a free-running system clock. A high level on a channel's reset clears both of its stages at once, without waiting for any clock edge.

The stages are linked only by wiring outside the block: an output is routed back to a clock pin. Feeding the one-bit stage's output into the modulo-five stage's pin gives a BCD count from 0 to 9. Feeding the top bit of the modulo-five stage into the one-bit stage's pin gives a bi-quinary count, with a symmetric divide-by-ten on the low bit. Chaining the top bit of one BCD channel into the next channel gives division by 100. Each stage that is fed from another stage responds a fixed number of system cycles later, which stands in for the ripple delay of a cascade.

Top module: `dual_decade_counter`

## Requirements
- R1: The channels are independent. Pin activity or reset on one channel never changes the outputs of the other channel.
- R2: When `clk_a[c]` falls, the channel's low bit toggles. A pin level first present before system edge k shows its effect on the output after system edge k+1, not before.
- R3: The modulo-five stage holds a 3-bit value with its least significant bit at QB. It steps 0,1,2,3,4 and then back to 0, once per falling edge of `clk_b[c]`, and never holds 5, 6 or 7.
- R4: A rising edge on either clock pin, or a pin held at a steady level, leaves both stages unchanged.
- R5: A high level on `rst_ch[c]` clears all four outputs of channel c right away, before the next system clock edge.
- R6: While `rst_ch[c]` is high, pin edges are ignored. If a pin is held low when reset is released, that does not cause a count.
- R7: Output layout: `q_out[4c]` is QA (the one-bit stage), `q_out[4c+1]` is QB, `q_out[4c+2]` is QC and `q_out[4c+3]` is QD (the modulo-five value, with QB as the LSB).
- R8: With QA of a channel wired to its `clk_b`, the four outputs of that channel read as a BCD value. The value goes from 0 to 9 and then back to 0, once per falling edge of `clk_a`.
- R9: With QD wired to `clk_a`, QB..QC..QD count modulo five on `clk_b` falls, and QA toggles on each 4-to-0 wrap. QA therefore divides the `clk_b` rate by ten.
- R10: With channel 0 in BCD mode, its QD driving channel 1's `clk_a`, and channel 1 also in BCD mode, the two channels hold tens and units of the falling-edge count on channel 0's `clk_a`, modulo 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock that samples the pins |
| rst_ch | input | NCH | Per-channel asynchronous active-high clear |
| clk_a | input | NCH | Per-channel clock pin of the one-bit stage |
| clk_b | input | NCH | Per-channel clock pin of the modulo-five stage |
| q_out | output | 4*NCH | Per-channel outputs {QD,QC,QB,QA} |

## Verification
The assertions check the following on every cycle:
- the modulo-five value stays in range;
- each count enable moves a stage exactly one step;
- a stage holds its value when it has no enable;
- an enable never lasts more than one cycle;
- no enable appears while reset is high;
- a sampled reset shows cleared outputs.

Some behaviour only the bench's scenarios can show. This covers the exact two-cycle latency from a pin and the clearing between clock edges. It also covers the absence of a false count when reset is released with a pin held low. Finally, it covers the counting sequences that arise when outputs are wired back to pins: BCD, bi-quinary and the two-channel divide-by-100.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  localparam int HALF_MOD = 2;
  localparam int QUIN_MOD = 5;
  localparam int QUIN_W   = $clog2(QUIN_MOD);
  localparam int CH_W     = 1 + QUIN_W;
  typedef logic [QUIN_W-1:0] quin_t;
endpackage

// File: rtl/dcnt_fall_det.sv
module dcnt_fall_det (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);
  logic smp;
  logic prev;

  // Tracks the pin even during reset so a held level never looks like an edge.
  always_ff @(posedge clk) begin
    smp  <= pin;
    prev <= smp;
  end

  assign fall = prev & ~smp & ~rst;

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
  a_r6_quiet_in_reset: assert property (@(posedge clk)
    rst |-> !fall);
endmodule

// File: rtl/dcnt_modn.sv
module dcnt_modn #(
  parameter int MOD = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic [((MOD > 2) ? $clog2(MOD) : 1)-1:0] cnt
);
  localparam int W = (MOD > 2) ? $clog2(MOD) : 1;
  localparam logic [W-1:0] TOP = W'(MOD - 1);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)      cnt <= '0;
    else if (en)  cnt <= (cnt == TOP) ? '0 : cnt + 1'b1;
  end

  a_r3_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= TOP);
  a_r2_one_step: assert property (@(posedge clk) disable iff (rst)
    en |=> (cnt == (($past(cnt) == TOP) ? '0 : W'($past(cnt) + 1'b1))));
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt));
  a_r5_cleared: assert property (@(posedge clk)
    rst |-> cnt == '0);
endmodule

// File: rtl/dcnt_channel.sv
module dcnt_channel
  import dcnt_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            pin_a,
  input  logic            pin_b,
  output logic [CH_W-1:0] q
);
  logic  en_a;
  logic  en_b;
  logic  half;
  quin_t quin;

  dcnt_fall_det u_det_a (.clk(clk), .rst(rst), .pin(pin_a), .fall(en_a));
  dcnt_fall_det u_det_b (.clk(clk), .rst(rst), .pin(pin_b), .fall(en_b));

  dcnt_modn #(.MOD(HALF_MOD)) u_half (.clk(clk), .rst(rst), .en(en_a), .cnt(half));
  dcnt_modn #(.MOD(QUIN_MOD)) u_quin (.clk(clk), .rst(rst), .en(en_b), .cnt(quin));

  // R7: QA at bit 0, modulo-five value above it.
  assign q = {quin, half};
endmodule

// File: rtl/dual_decade_counter.sv
module dual_decade_counter
  import dcnt_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic              clk,
  input  logic [NCH-1:0]    rst_ch,
  input  logic [NCH-1:0]    clk_a,
  input  logic [NCH-1:0]    clk_b,
  output logic [CH_W*NCH-1:0] q_out
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dcnt_channel u_ch (
      .clk   (clk),
      .rst   (rst_ch[g]),
      .pin_a (clk_a[g]),
      .pin_b (clk_b[g]),
      .q     (q_out[CH_W*g +: CH_W])
    );
  end
endmodule

// File: tb/sim_dual_decade_counter.sv
module sim_dual_decade_counter;
  localparam int CLK_P = 10;
  localparam int NCH   = 2;

  logic         clk = 1'b0;
  logic [1:0]   rst_ch;
  logic [1:0]   drv_a, drv_b, ca, cb;
  logic [7:0]   q;
  int           mode;
  int           n_chk = 0;
  int           n_bad = 0;
  bit           done = 0;

  always #(CLK_P/2) clk = ~clk;

  dual_decade_counter #(.NCH(NCH)) u0 (
    .clk(clk), .rst_ch(rst_ch), .clk_a(ca), .clk_b(cb), .q_out(q));

  always_comb begin
    ca = drv_a;
    cb = drv_b;
    case (mode)
      1: cb[0] = q[0];
      2: ca[0] = q[3];
      3: begin cb[0] = q[0]; ca[1] = q[3]; cb[1] = q[4]; end
      default: ;
    endcase
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_ch(input int na, input int nb);
    return {3'(nb % 5), 1'(na % 2)};
  endfunction

  function automatic logic [3:0] exp_biq(input int n);
    return {3'(n % 5), 1'((n / 5) % 2)};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reset_to(input int m);
    @(negedge clk);
    rst_ch = 2'b11;
    drv_a = '0; drv_b = '0;
    mode = m;
    cyc(4);
    rst_ch = 2'b00;
    cyc(4);
  endtask

  task automatic pulse_a0;
    drv_a[0] = 1'b1;
    cyc(1 + int'($urandom_range(3)));
    drv_a[0] = 1'b0;
    cyc(12);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    int na[2], nb[2];
    logic [3:0] keep;
    void'($urandom(32'd2024));
    rst_ch = 2'b11; drv_a = '0; drv_b = '0; mode = 0;
    cyc(5);
    chk("R5 reset state", 32'(q), 32'h0);
    rst_ch = 2'b00;
    cyc(4);

    // R2 latency: pin fall before edge k shows after edge k+1.
    drv_a[0] = 1'b1; cyc(4);
    chk("R4 rising edge no count", 32'(q[3:0]), 32'h0);
    drv_a[0] = 1'b0;
    cyc(1);
    chk("R2 no change after first edge", 32'(q[0]), 32'h0);
    cyc(1);
    chk("R2 toggle after second edge", 32'(q[0]), 32'h1);
    chk("R1 channel 1 untouched", 32'(q[7:4]), 32'h0);

    // R5: clear between clock edges.
    drv_b[0] = 1'b1; cyc(3); drv_b[0] = 1'b0; cyc(4);
    chk("R7 QA and QB layout", 32'(q[3:0]), 32'h3);
    rst_ch[0] = 1'b1;
    #1;
    chk("R5 async clear", 32'(q[3:0]), 32'h0);
    // R6: edges during reset ignored, low level at release no count.
    cyc(1);
    drv_a[0] = 1'b1; cyc(3); drv_a[0] = 1'b0; cyc(3);
    rst_ch[0] = 1'b0;
    cyc(6);
    chk("R6 no count at release", 32'(q[3:0]), 32'h0);
    pulse_a0();
    chk("R6 counts after release", 32'(q[3:0]), 32'h1);

    // R1/R3/R4 direct random.
    reset_to(0);
    na = '{0, 0}; nb = '{0, 0};
    for (int i = 0; i < 300; i++) begin
      logic [1:0] na_v, nb_v;
      na_v = 2'($urandom); nb_v = 2'($urandom);
      if (i % 50 == 7) begin na_v = drv_a; nb_v = drv_b; end
      for (int c = 0; c < 2; c++) begin
        if (drv_a[c] && !na_v[c]) na[c]++;
        if (drv_b[c] && !nb_v[c]) nb[c]++;
      end
      drv_a = na_v; drv_b = nb_v;
      cyc(3);
      chk("R3 R1 direct ch0", 32'(q[3:0]), 32'(exp_ch(na[0], nb[0])));
      chk("R3 R1 direct ch1", 32'(q[7:4]), 32'(exp_ch(na[1], nb[1])));
    end
    keep = q[7:4];
    rst_ch[0] = 1'b1; cyc(2); rst_ch[0] = 1'b0; cyc(2);
    chk("R1 reset of ch0 spares ch1", 32'(q[7:4]), 32'(keep));

    // R8 BCD.
    reset_to(1);
    for (int n = 1; n <= 25; n++) begin
      pulse_a0();
      chk("R8 BCD count", 32'(q[3:0]), 32'(n % 10));
    end

    // R9 bi-quinary.
    reset_to(2);
    for (int n = 1; n <= 25; n++) begin
      drv_b[0] = 1'b1; cyc(1 + int'($urandom_range(3)));
      drv_b[0] = 1'b0; cyc(12);
      chk("R9 bi-quinary count", 32'(q[3:0]), 32'(exp_biq(n)));
    end

    // R10 chained divide by 100.
    reset_to(3);
    for (int n = 1; n <= 205; n++) begin
      pulse_a0();
      chk("R10 chained units", 32'(q[3:0]), 32'(n % 10));
      chk("R10 chained tens", 32'(q[7:4]), 32'((n / 10) % 10));
    end

    done = 1;
    report();
    $finish;
  end
endmodule